// File: doc/BRIEF.md
# Tile-Buffer Pixel Color Generator

This block turns a tile buffer of triangle identifiers into a 24-bit RGB stream for a VGA display. Its core clock runs ten times faster than the pixel clock, and a one-cycle strobe marks each new pixel. On each strobe the block checks whether the pixel coordinate lies inside the visible 640x480 window. For a visible pixel it then does three things in order. First it reads the tile-buffer word for that column. Next it selects the identifier for the row the pixel sits on inside its four-row tile. Last it fetches that triangle's light intensity and base color from two attribute memories that share one address. From these values it computes the shaded color in Q9.9 fixed point, using one of four modes chosen by the top two bits of a configuration word.

The computed color waits in a holding register and moves to the output on the next strobe. The output is therefore a stable one-pixel-delayed stream that changes only when a strobe arrives. Pixels outside the window produce black.

When the strobe for the first blanking column of a tile's bottom visible row arrives, the block resets the tile-buffer row to empty. It writes an all-invalid entry to every column, one per core cycle, while horizontal blanking runs. The rasterizer can then refill the same storage with the next tile.

Top module: `tile_pixel_shader`

## Requirements
- R1: While reset is held and on the first cycles after it, `rgb_out` is zero and `tile_wr_en` is low.
- R2: The color for the pixel of strobe k appears on `rgb_out` in the cycle after strobe k+1. It stays unchanged until the cycle after the following strobe. Strobes are assumed to be at least 10 cycles apart.
- R3: For a visible pixel, `tile_rd_addr` equals x in the strobe cycle, and the tile word returns one cycle later. The identifier is bits [12*r+11 : 12*r] of that word, where r = y[1:0]. That identifier drives `attr_addr` in the next cycle, and light and color return one cycle after that.
- R4: In mode 00 (`color_cfg[15:14]`), the output is the base color. The base color is packed as R in [23:16], G in [15:8] and B in [7:0].
- R5: In mode 01, each channel is floor(c * g / 512). Here c is the base channel, and g is the 10-bit unsigned intensity (9 fraction bits) clamped to at most 512 (1.0).
- R6: In mode 10, all three channels equal floor(255 * g / 512), with g clamped as in R5.
- R7: In mode 11, the output is the debug color: R = id[7:0], G = id[11:4], B = ~id[7:0].
- R8: An identifier of all ones (0xFFF) means no triangle. Such a pixel is black in every mode.
- R9: A pixel with x >= 640 or y >= 480 is black.
- R10: A strobe with x == 640, y < 480 and y[1:0] == 3 starts the flush on the next cycle. The flush writes an all-ones word to tile addresses 0 to 639, in ascending order, one per cycle, with no gaps.
- R11: A strobe with x == 640 starts no writes if y[1:0] != 3 or if y >= 480.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_stb | input | 1 | One-cycle strobe marking a new pixel |
| pix_x | input | 10 | Column of the pixel being scanned |
| pix_y | input | 10 | Row of the pixel being scanned |
| color_cfg | input | 16 | Configuration word; bits [15:14] pick the shading mode |
| tile_rd_addr | output | 10 | Tile-buffer read column |
| tile_rd_data | input | 48 | Tile word, four packed 12-bit identifiers, one cycle after the address |
| tile_wr_en | output | 1 | Tile-buffer write enable (flush) |
| tile_wr_addr | output | 10 | Tile-buffer write column |
| tile_wr_data | output | 48 | Tile-buffer write data (all invalid identifiers) |
| attr_addr | output | 12 | Triangle identifier addressing the light and color memories |
| light_data | input | 10 | Light intensity, unsigned with 9 fraction bits, one cycle after the address |
| base_color | input | 24 | Base color {R,G,B}, one cycle after the address |
| rgb_out | output | 24 | Pixel color {R,G,B} |

## Verification
The hardest case to reach from the ports is the row flush. It needs a strobe at exactly the first blanking column of a bottom tile row. Then about seventy blanking strobes must follow while 640 writes go out. After that, the tile contents must be observed through later visible pixels. The bench builds this sequence directly. It counts the writes and checks their order and start cycle. It also drives near-miss strobes at x == 640 (other rows, and a bottom row below the window) and checks that they start no writes. After the flush, every visible pixel must come out black. A bench-side memory port then reloads fresh identifiers. Random pixels in all four modes cover both the clamped and the unclamped intensity range.

// File: rtl/tile_pixel_shader_pkg.sv
package tile_pixel_shader_pkg;
  // fraction bits of the Q9.9 shading format
  localparam int QFRAC = 9;

  typedef enum logic [1:0] {
    ST_TILE  = 2'd0,
    ST_ATTR  = 2'd1,
    ST_CALC  = 2'd2,
    ST_FLUSH = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    SHM_FLAT  = 2'd0,
    SHM_LIT   = 2'd1,
    SHM_GREY  = 2'd2,
    SHM_DEBUG = 2'd3
  } shade_mode_e;
endpackage

// File: rtl/tps_sequencer.sv
module tps_sequencer
  import tile_pixel_shader_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 480,
  parameter int XW       = 10,
  parameter int YW       = 10,
  parameter int ROW_W    = 2,
  parameter int COL_AW   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_stb,
  input  logic [XW-1:0]     pix_x,
  input  logic [YW-1:0]     pix_y,
  input  logic [1:0]        mode_in,
  output seq_state_e        state,
  output logic              visible,
  output logic              launch,
  output logic              attr_phase,
  output logic              calc_phase,
  output logic              blank_stb,
  output logic [ROW_W-1:0]  row_q,
  output shade_mode_e       mode_q,
  output logic [COL_AW-1:0] tile_rd_addr,
  output logic              flush_wr_en,
  output logic [COL_AW-1:0] flush_wr_addr
);
  localparam logic [COL_AW-1:0] COL_LAST = COL_AW'(H_ACTIVE - 1);
  localparam logic [XW-1:0]     X_END    = XW'(H_ACTIVE);
  localparam logic [YW-1:0]     Y_END    = YW'(V_ACTIVE);

  logic              flush_start;
  logic [COL_AW-1:0] flush_col;

  always_comb begin
    visible      = (pix_x < X_END) && (pix_y < Y_END);
    launch       = pix_stb && visible && (state == ST_TILE);
    blank_stb    = pix_stb && !visible;
    flush_start  = pix_stb && (state == ST_TILE) && (pix_x == X_END) &&
                   (pix_y < Y_END) && (&pix_y[ROW_W-1:0]);
    tile_rd_addr = pix_x[COL_AW-1:0];
    attr_phase   = (state == ST_ATTR);
    calc_phase   = (state == ST_CALC);
    flush_wr_en  = (state == ST_FLUSH);
    flush_wr_addr = flush_col;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_TILE;
      row_q     <= '0;
      mode_q    <= SHM_FLAT;
      flush_col <= '0;
    end else begin
      unique case (state)
        ST_TILE: begin
          if (launch) begin
            row_q  <= pix_y[ROW_W-1:0];
            mode_q <= shade_mode_e'(mode_in);
            state  <= ST_ATTR;
          end else if (flush_start) begin
            flush_col <= '0;
            state     <= ST_FLUSH;
          end
        end
        ST_ATTR: state <= ST_CALC;
        ST_CALC: state <= ST_TILE;
        ST_FLUSH: begin
          if (flush_col == COL_LAST) begin
            flush_col <= '0;
            state     <= ST_TILE;
          end else begin
            flush_col <= flush_col + 1'b1;
          end
        end
        default: state <= ST_TILE;
      endcase
    end
  end

  // flush begins at column zero and only after a qualifying strobe
  assert_flush_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_wr_en) |-> (flush_wr_addr == '0));
  assert_flush_ascend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_wr_en && $past(flush_wr_en)) |-> (flush_wr_addr == $past(flush_wr_addr) + 1'b1));
  assert_flush_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_wr_en) |-> $past(flush_start));
  assert_no_pixel_in_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_wr_en |-> !(pix_stb && visible));
  assert_stb_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (attr_phase || calc_phase) |-> !pix_stb);
endmodule

// File: rtl/tps_id_pick.sv
module tps_id_pick #(
  parameter int ID_W      = 12,
  parameter int TILE_ROWS = 4,
  parameter int ROW_W     = 2
) (
  input  logic [TILE_ROWS*ID_W-1:0] entry,
  input  logic [ROW_W-1:0]          row,
  output logic [ID_W-1:0]           id
);
  logic [ID_W-1:0] slot [TILE_ROWS];

  for (genvar g = 0; g < TILE_ROWS; g++) begin : g_slot
    assign slot[g] = entry[g*ID_W +: ID_W];
  end

  assign id = slot[row];
endmodule

// File: rtl/tps_shader.sv
module tps_shader
  import tile_pixel_shader_pkg::*;
#(
  parameter int ID_W  = 12,
  parameter int INT_W = 10,
  parameter int CH_W  = 8
) (
  input  shade_mode_e        mode,
  input  logic [ID_W-1:0]    id,
  input  logic [3*CH_W-1:0]  base,
  input  logic [INT_W-1:0]   intensity,
  output logic [3*CH_W-1:0]  rgb
);
  localparam int RGB_W = 3 * CH_W;
  localparam int QW    = CH_W + 1 + QFRAC;   // Q9.9 operand
  localparam int PW    = QW + QFRAC + 1;     // product width
  localparam int ONE   = 1 << QFRAC;

  function automatic logic [QFRAC:0] clamp_gain(input logic [INT_W-1:0] i);
    if (int'(i) > ONE) return (QFRAC+1)'(ONE);
    return i[QFRAC:0];
  endfunction

  function automatic logic [CH_W-1:0] scale_chan(input logic [CH_W-1:0] c,
                                                 input logic [QFRAC:0] g);
    logic [QW-1:0] c_q;
    logic [PW-1:0] prod;
    c_q  = {1'b0, c, {QFRAC{1'b0}}};
    prod = PW'(c_q) * PW'(g);
    return prod[2*QFRAC +: CH_W];
  endfunction

  function automatic logic [RGB_W-1:0] debug_color(input logic [ID_W-1:0] t);
    return {t[CH_W-1:0], t[ID_W-1 -: CH_W], ~t[CH_W-1:0]};
  endfunction

  logic [QFRAC:0]     gain;
  logic [RGB_W-1:0]   lit;
  logic [CH_W-1:0]    grey;

  assign gain = clamp_gain(intensity);
  assign grey = scale_chan({CH_W{1'b1}}, gain);

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    assign lit[ch*CH_W +: CH_W] = scale_chan(base[ch*CH_W +: CH_W], gain);
  end

  always_comb begin
    if (&id) begin
      rgb = '0;
    end else begin
      unique case (mode)
        SHM_FLAT:  rgb = base;
        SHM_LIT:   rgb = lit;
        SHM_GREY:  rgb = {grey, grey, grey};
        SHM_DEBUG: rgb = debug_color(id);
        default:   rgb = '0;
      endcase
    end
  end
endmodule

// File: rtl/tps_out_stage.sv
module tps_out_stage #(
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_stb,
  input  logic             blank_stb,
  input  logic             calc_phase,
  input  logic [RGB_W-1:0] calc_rgb,
  output logic [RGB_W-1:0] rgb_next,
  output logic [RGB_W-1:0] rgb_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgb_next <= '0;
      rgb_out  <= '0;
    end else begin
      if (blank_stb)       rgb_next <= '0;
      else if (calc_phase) rgb_next <= calc_rgb;
      if (pix_stb)         rgb_out  <= rgb_next;
    end
  end

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_stb |=> $stable(rgb_out));
  assert_blank_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blank_stb |=> (rgb_next == '0));
endmodule

// File: rtl/tile_pixel_shader.sv
module tile_pixel_shader
  import tile_pixel_shader_pkg::*;
#(
  parameter int H_ACTIVE  = 640,
  parameter int V_ACTIVE  = 480,
  parameter int XW        = 10,
  parameter int YW        = 10,
  parameter int TILE_ROWS = 4,
  parameter int ID_W      = 12,
  parameter int INT_W     = 10,
  parameter int CH_W      = 8,
  parameter int CFG_W     = 16,
  localparam int ROW_W    = $clog2(TILE_ROWS),
  localparam int ENTRY_W  = TILE_ROWS * ID_W,
  localparam int RGB_W    = 3 * CH_W,
  localparam int COL_AW   = $clog2(H_ACTIVE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_stb,
  input  logic [XW-1:0]      pix_x,
  input  logic [YW-1:0]      pix_y,
  input  logic [CFG_W-1:0]   color_cfg,
  output logic [COL_AW-1:0]  tile_rd_addr,
  input  logic [ENTRY_W-1:0] tile_rd_data,
  output logic               tile_wr_en,
  output logic [COL_AW-1:0]  tile_wr_addr,
  output logic [ENTRY_W-1:0] tile_wr_data,
  output logic [ID_W-1:0]    attr_addr,
  input  logic [INT_W-1:0]   light_data,
  input  logic [RGB_W-1:0]   base_color,
  output logic [RGB_W-1:0]   rgb_out
);
  seq_state_e       state;
  shade_mode_e      mode_q;
  logic             visible, launch, attr_phase, calc_phase, blank_stb;
  logic [ROW_W-1:0] row_q;
  logic [ID_W-1:0]  picked_id, id_q;
  logic [RGB_W-1:0] calc_rgb, rgb_next;
  logic             cfg_unused;

  assign cfg_unused   = ^color_cfg[CFG_W-3:0];
  assign tile_wr_data = '1;
  assign attr_addr    = picked_id;

  tps_sequencer #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .XW(XW), .YW(YW),
    .ROW_W(ROW_W), .COL_AW(COL_AW)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .pix_x(pix_x), .pix_y(pix_y),
    .mode_in(color_cfg[CFG_W-1 -: 2]), .state(state), .visible(visible),
    .launch(launch), .attr_phase(attr_phase), .calc_phase(calc_phase),
    .blank_stb(blank_stb), .row_q(row_q), .mode_q(mode_q),
    .tile_rd_addr(tile_rd_addr), .flush_wr_en(tile_wr_en),
    .flush_wr_addr(tile_wr_addr)
  );

  tps_id_pick #(.ID_W(ID_W), .TILE_ROWS(TILE_ROWS), .ROW_W(ROW_W)) pick_i (
    .entry(tile_rd_data), .row(row_q), .id(picked_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          id_q <= '1;
    else if (attr_phase) id_q <= picked_id;
  end

  tps_shader #(.ID_W(ID_W), .INT_W(INT_W), .CH_W(CH_W)) shade_i (
    .mode(mode_q), .id(id_q), .base(base_color), .intensity(light_data),
    .rgb(calc_rgb)
  );

  tps_out_stage #(.RGB_W(RGB_W)) out_i (
    .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .blank_stb(blank_stb),
    .calc_phase(calc_phase), .calc_rgb(calc_rgb), .rgb_next(rgb_next),
    .rgb_out(rgb_out)
  );

  // an empty tile slot leaves black in the holding register
  assert_empty_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_phase && (&id_q)) |=> (rgb_next == '0));
  // a visible pixel walks tile read, then attribute read, then shading
  assert_launch_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> attr_phase);
  assert_attr_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    attr_phase |=> calc_phase);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!tile_wr_en && rgb_out == '0));
endmodule

// File: tb/tile_pixel_shader_tb_top.sv
module tile_pixel_shader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_stb = 1'b0;
  logic [9:0]  pix_x = '0;
  logic [9:0]  pix_y = '0;
  logic [15:0] color_cfg = '0;
  logic [9:0]  tile_rd_addr, tile_wr_addr;
  logic [47:0] tile_rd_data, tile_wr_data;
  logic        tile_wr_en;
  logic [11:0] attr_addr;
  logic [9:0]  light_data;
  logic [23:0] base_color, rgb_out;

  always #4 clk = ~clk;

  tile_pixel_shader dut_i (
    .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .pix_x(pix_x), .pix_y(pix_y),
    .color_cfg(color_cfg), .tile_rd_addr(tile_rd_addr), .tile_rd_data(tile_rd_data),
    .tile_wr_en(tile_wr_en), .tile_wr_addr(tile_wr_addr), .tile_wr_data(tile_wr_data),
    .attr_addr(attr_addr), .light_data(light_data), .base_color(base_color),
    .rgb_out(rgb_out)
  );

  function automatic logic [9:0] light_fn(input logic [11:0] id);
    return 10'((int'(id) * 7 + 3) % 1024);
  endfunction

  function automatic logic [23:0] color_fn(input logic [11:0] id);
    logic [7:0] r, g, b;
    r = id[7:0] ^ 8'hA5;
    g = id[11:4] + 8'd17;
    b = 8'((int'(id) * 5) % 256);
    return {r, g, b};
  endfunction

  // memory models plus bench-side loading port
  logic [47:0] tile_mem [640];
  logic [47:0] ref_tile [640];
  logic        bw_en = 1'b0;
  logic [9:0]  bw_addr = '0;
  logic [47:0] bw_data = '0;
  int cyc = 0, wr_total = 0, trig_cyc = 0, first_wr_cyc = 0;
  int order_err = 0, data_err = 0;
  logic [9:0] last_wr_addr = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bw_en) tile_mem[bw_addr] <= bw_data;
    else if (tile_wr_en && tile_wr_addr < 10'd640) tile_mem[tile_wr_addr] <= tile_wr_data;
    tile_rd_data <= (tile_rd_addr < 10'd640) ? tile_mem[tile_rd_addr] : 48'h0;
    light_data   <= light_fn(attr_addr);
    base_color   <= color_fn(attr_addr);
    if (pix_stb && pix_x == 10'd640) trig_cyc <= cyc;
    if (tile_wr_en) begin
      wr_total     <= wr_total + 1;
      last_wr_addr <= tile_wr_addr;
      if (tile_wr_addr == 10'd0) first_wr_cyc <= cyc;
      else if (tile_wr_addr != last_wr_addr + 10'd1) order_err <= order_err + 1;
      if (tile_wr_data != {48{1'b1}}) data_err <= data_err + 1;
    end
  end

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  function automatic logic [23:0] exp_rgb(input int x, input int y, input logic [1:0] m);
    logic [11:0] id;
    logic [23:0] bc;
    int g, v;
    if (x >= 640 || y >= 480) return 24'h0;
    id = ref_tile[x][(y % 4) * 12 +: 12];
    if (id == 12'hFFF) return 24'h0;
    g  = int'(light_fn(id));
    if (g > 512) g = 512;
    bc = color_fn(id);
    case (m)
      2'd0: return bc;
      2'd1: return {8'((int'(bc[23:16]) * g) / 512), 8'((int'(bc[15:8]) * g) / 512),
                    8'((int'(bc[7:0]) * g) / 512)};
      2'd2: begin v = (255 * g) / 512; return {8'(v), 8'(v), 8'(v)}; end
      default: return {id[7:0], id[11:4], ~id[7:0]};
    endcase
  endfunction

  function automatic string tag_of(input int x, input int y, input logic [1:0] m);
    if (x >= 640 || y >= 480) return "R9";
    if (ref_tile[x][(y % 4) * 12 +: 12] == 12'hFFF) return "R8";
    case (m)
      2'd0: return "R2 R3 R4";
      2'd1: return "R2 R3 R5";
      2'd2: return "R2 R3 R6";
      default: return "R2 R3 R7";
    endcase
  endfunction

  logic [23:0] prev_exp = '0;
  string       prev_tag = "R1";
  bit          have_prev = 1'b0;

  // one pixel period of 10 cycles; checks the previous pixel's color
  task automatic send_pix(input int x, input int y, input logic [1:0] m);
    logic [23:0] shown;
    @(negedge clk);
    pix_stb = 1'b1; pix_x = 10'(x); pix_y = 10'(y); color_cfg = {m, 14'h2b3c};
    @(negedge clk);
    pix_stb = 1'b0;
    if (have_prev) chk(prev_tag, 64'(rgb_out), 64'(prev_exp));
    shown = rgb_out;
    prev_exp = exp_rgb(x, y, m); prev_tag = tag_of(x, y, m); have_prev = 1'b1;
    repeat (7) @(negedge clk);
    chk("R2 hold", 64'(rgb_out), 64'(shown));
    @(negedge clk);
  endtask

  task automatic bwrite(input int a, input logic [47:0] d);
    @(negedge clk);
    bw_en = 1'b1; bw_addr = 10'(a); bw_data = d;
    ref_tile[a] = d;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  function automatic logic [47:0] rand_entry();
    logic [47:0] e;
    for (int r = 0; r < 4; r++) begin
      e[r*12 +: 12] = (($urandom % 8) == 0) ? 12'hFFF : 12'($urandom % 4095);
    end
    return e;
  endfunction

  task automatic load_all();
    for (int a = 0; a < 640; a++) bwrite(a, rand_entry());
  endtask

  task automatic rand_pixels(input int n);
    for (int k = 0; k < n; k++) begin
      int x, y;
      x = int'($urandom % 720);
      y = int'($urandom % 500);
      if (($urandom % 4) != 0) begin x = x % 640; y = y % 480; end
      if (x == 640 && y < 480 && (y % 4) == 3) x = 641;
      send_pix(x, y, 2'($urandom % 4));
    end
  endtask

  initial begin
    int w0;
    void'($urandom(32'd20240611));
    load_all();
    // R1: quiet during and just after reset
    chk("R1 rgb", 64'(rgb_out), 64'h0);
    chk("R1 wr_en", 64'(tile_wr_en), 64'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rgb after release", 64'(rgb_out), 64'h0);
    chk("R1 wr_en after release", 64'(tile_wr_en), 64'h0);

    // directed: known ids in column 5, every row and mode (R3..R8)
    bwrite(5, {12'd100, 12'hFFF, 12'd10, 12'd2049});
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 4; r++) send_pix(5, 8 + r, 2'(m));
    // corners and outside the window (R9)
    send_pix(0, 0, 2'd1);
    send_pix(639, 479, 2'd3);
    send_pix(640, 10, 2'd0);
    send_pix(100, 480, 2'd0);
    send_pix(1023, 1023, 2'd2);
    send_pix(639, 0, 2'd2);

    rand_pixels(300);

    // R11: near-miss row ends start no writes
    w0 = wr_total;
    send_pix(640, 5, 2'd0);
    for (int k = 0; k < 70; k++) send_pix(700, 5, 2'd0);
    send_pix(640, 483, 2'd0);
    for (int k = 0; k < 70; k++) send_pix(700, 483, 2'd0);
    chk("R11 no writes", 64'(wr_total - w0), 64'h0);

    // R10: bottom row of a tile triggers the flush
    w0 = wr_total;
    send_pix(640, 7, 2'd0);
    for (int k = 0; k < 70; k++) send_pix(700, 7, 2'd0);
    chk("R10 write count", 64'(wr_total - w0), 64'd640);
    chk("R10 start cycle", 64'(first_wr_cyc - trig_cyc), 64'd1);
    chk("R10 ascending", 64'(order_err), 64'h0);
    chk("R10 data all ones", 64'(data_err), 64'h0);
    chk("R10 last address", 64'(last_wr_addr), 64'd639);
    for (int a = 0; a < 640; a++) ref_tile[a] = {48{1'b1}};
    rand_pixels(40);   // all visible pixels now black (R8, R10)

    load_all();
    rand_pixels(120);
    send_pix(700, 0, 2'd0);  // flush out last pending comparison
    finish_up();
  end
endmodule